// File: doc/BRIEF.md
# I2C Master SCL Rate Generator

This block produces the serial clock of an I2C master. It runs from a system clock and advances only on a periodic reference tick. A 5-bit divisor and a fast-mode select set the length of each low and high phase. The SCL output is open-drain style: the block either pulls the line low or releases it. It also watches the line as the bus actually presents it, so that a slave holding SCL low delays the high phase instead of shortening it.

Bit-level logic sits beside this block and is not part of it. That logic uses two one-cycle strobes: one marks the start of each low phase and one marks the first counted high tick. A flag reports a divisor that the selected mode does not allow. While that flag is set, the block stays silent.

In standard mode one SCL period is eight times the divisor, in ticks. In fast mode it is four times the divisor. One fast-mode divisor is special: it selects a fixed 10-tick period with a long low phase, which reaches the top fast-mode rate and still meets the minimum low time.

Top module: `scl_rate_gen`

## Requirements
- R1: With fast_mode=0 and a legal divisor D, each low phase lasts 4×D ticks and each released (high) phase lasts 4×D ticks when no device stretches the clock.
- R2: With fast_mode=1 and a legal divisor D other than 5, the low and high phases each last 2×D ticks.
- R3: With fast_mode=1 and divisor 5, the low phase lasts 6 ticks and the high phase 4 ticks.
- R4: Divisors 0, 1 and 2 in either mode, and divisors 3 and 4 with fast_mode=0, are illegal. For an illegal setting, bad_setting is 1, SCL is released and neither strobe fires. When a legal value returns, a fresh full low phase starts. For legal settings bad_setting is 0.
- R5: During the high phase a tick counts only when scl_in is sampled high. A tick where an external device holds SCL low lengthens the released phase by one tick.
- R6: While enable is 0, scl_drive_low and both strobes are 0 in the same cycle. Re-enabling restarts with a full low phase, because both phase counters were reset.
- R7: low_start is a one-cycle pulse in the first cycle that scl_drive_low is 1. high_start is a one-cycle pulse once per high phase. The two never fire together.
- R8: During and right after reset, scl_drive_low, low_start and high_start are 0.
- R9: The first low phase after enable is set with a legal setting begins on the next reference tick: low_start appears within one tick period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Reference tick, one clk wide, advances the phase counters |
| enable | input | 1 | Run the clock generator |
| fast_mode | input | 1 | 0 selects standard mode, 1 selects fast mode |
| divisor | input | 5 | Rate divisor, 0 to 31 |
| scl_in | input | 1 | SCL level as seen on the bus |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| low_start | output | 1 | One-cycle strobe at the start of a low phase |
| high_start | output | 1 | One-cycle strobe at the first counted high tick |
| bad_setting | output | 1 | The divisor is illegal for the selected mode |

## Verification
The phase lengths are measured at several points:
- Standard mode at its smallest legal divisor, a middle value and the largest value.
- Fast mode at its smallest legal divisor, at 4, at the special value 5, at 6 and at 31.

The 4, 5 and 6 neighbours tell the asymmetric 6/4 split apart from the plain 2×D rule. The standard/fast pairs tell the 4×D multiplier apart from the 2×D multiplier. Every illegal divisor in each mode is tried. A deliberate stretch of five ticks shows that the high phase counts bus-visible high ticks and not elapsed ticks. Dropping enable, and moving to an illegal divisor mid-phase, show that the counters restart from zero.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // Setting check: a floor for both modes and a higher floor for standard mode.
  function automatic bit cfg_illegal(input bit fast, input int unsigned div,
                                     input int unsigned any_floor,
                                     input int unsigned std_floor);
    if (div < any_floor) return 1'b1;
    if (!fast && div < std_floor) return 1'b1;
    return 1'b0;
  endfunction

  // Low phase length in ticks.
  function automatic int unsigned low_ticks(input bit fast, input int unsigned div,
                                            input int unsigned odd_div,
                                            input int unsigned odd_low);
    if (!fast) return 4 * div;
    if (div == odd_div) return odd_low;
    return 2 * div;
  endfunction

  // High phase length in ticks.
  function automatic int unsigned high_ticks(input bit fast, input int unsigned div,
                                             input int unsigned odd_div,
                                             input int unsigned odd_high);
    if (!fast) return 4 * div;
    if (div == odd_div) return odd_high;
    return 2 * div;
  endfunction

endpackage

// File: rtl/scl_phase_calc.sv
module scl_phase_calc
  import scl_gen_pkg::*;
#(
  parameter int DIV_W     = 5,
  parameter int CNT_W     = DIV_W + 2,
  parameter int ANY_FLOOR = 3,
  parameter int STD_FLOOR = 5,
  parameter int ODD_DIV   = 5,
  parameter int ODD_LOW   = 6,
  parameter int ODD_HIGH  = 4
) (
  input  logic             fast,
  input  logic [DIV_W-1:0] div,
  output logic [CNT_W-1:0] low_len,
  output logic [CNT_W-1:0] high_len,
  output logic             illegal
);

  int unsigned div_u;

  always_comb begin
    div_u    = int'(div);
    illegal  = cfg_illegal(fast, div_u, ANY_FLOOR, STD_FLOOR);
    low_len  = CNT_W'(low_ticks(fast, div_u, ODD_DIV, ODD_LOW));
    high_len = CNT_W'(high_ticks(fast, div_u, ODD_DIV, ODD_HIGH));
  end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             scl_in,
  input  logic [CNT_W-1:0] low_len,
  input  logic [CNT_W-1:0] high_len,
  output logic             drive_low,
  output logic             low_start,
  output logic             high_start
);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             low_start_q;
  logic             high_start_q;

  // Named events for the assertions.
  logic low_done;
  logic high_done;
  logic high_counts;

  assign high_counts = (phase == PH_HIGH) && scl_in;
  assign low_done    = (cnt >= low_len - CNT_W'(1));
  assign high_done   = (cnt >= high_len - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase        <= PH_IDLE;
      cnt          <= '0;
      low_start_q  <= 1'b0;
      high_start_q <= 1'b0;
    end else begin
      low_start_q  <= 1'b0;
      high_start_q <= 1'b0;
      if (!run) begin
        phase <= PH_IDLE;
        cnt   <= '0;
      end else if (tick) begin
        unique case (phase)
          PH_IDLE: begin
            phase       <= PH_LOW;
            cnt         <= '0;
            low_start_q <= 1'b1;
          end
          PH_LOW: begin
            if (low_done) begin
              phase <= PH_HIGH;
              cnt   <= '0;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          PH_HIGH: begin
            if (high_counts) begin
              if (cnt == '0) high_start_q <= 1'b1;
              if (high_done) begin
                phase       <= PH_LOW;
                cnt         <= '0;
                low_start_q <= 1'b1;
              end else begin
                cnt <= cnt + CNT_W'(1);
              end
            end
          end
          default: begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end
        endcase
      end
    end
  end

  assign drive_low  = (phase == PH_LOW) && run;
  assign low_start  = low_start_q && run;
  assign high_start = high_start_q && run;

  // R7: a low phase strobe coincides with SCL being pulled low
  assert_low_strobe_drives_R7: assert property (@(posedge clk) disable iff (!rst_n)
    low_start |-> drive_low);

  // R7: the two strobes never coincide
  assert_strobes_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(low_start && high_start));

  // R5: a stretched tick does not advance the high counter
  assert_stretch_holds_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HIGH && run && tick && !scl_in) |=> (cnt == $past(cnt) || phase == PH_IDLE));

  // R5: SCL stays released for the whole high phase
  assert_high_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HIGH) |-> !drive_low);

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_gen_pkg::*;
#(
  parameter int DIV_W     = 5,
  parameter int ANY_FLOOR = 3,
  parameter int STD_FLOOR = 5,
  parameter int ODD_DIV   = 5,
  parameter int ODD_LOW   = 6,
  parameter int ODD_HIGH  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             enable,
  input  logic             fast_mode,
  input  logic [DIV_W-1:0] divisor,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             low_start,
  output logic             high_start,
  output logic             bad_setting
);

  localparam int CNT_W = DIV_W + 2;

  logic [CNT_W-1:0] low_len;
  logic [CNT_W-1:0] high_len;
  logic             illegal;
  logic             run;

  scl_phase_calc #(
    .DIV_W    (DIV_W),
    .CNT_W    (CNT_W),
    .ANY_FLOOR(ANY_FLOOR),
    .STD_FLOOR(STD_FLOOR),
    .ODD_DIV  (ODD_DIV),
    .ODD_LOW  (ODD_LOW),
    .ODD_HIGH (ODD_HIGH)
  ) u_calc (
    .fast    (fast_mode),
    .div     (divisor),
    .low_len (low_len),
    .high_len(high_len),
    .illegal (illegal)
  );

  assign run         = enable && !illegal;
  assign bad_setting = illegal;

  scl_phase_fsm #(
    .CNT_W(CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .run       (run),
    .scl_in    (scl_in),
    .low_len   (low_len),
    .high_len  (high_len),
    .drive_low (scl_drive_low),
    .low_start (low_start),
    .high_start(high_start)
  );

  // R6: disabled means released and silent
  assert_off_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!scl_drive_low && !low_start && !high_start));

  // R4: an illegal setting keeps the line released and the strobes quiet
  assert_bad_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bad_setting |-> (!scl_drive_low && !low_start && !high_start));

endmodule

// File: tb/scl_rate_gen_tb.sv
module scl_rate_gen_tb;

  localparam int TDIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       enable = 1'b0;
  logic       fast_mode = 1'b0;
  logic [4:0] divisor = 5'd10;
  logic       stretch = 1'b0;
  logic       scl_in;
  logic       scl_drive_low, low_start, high_start, bad_setting;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int tcnt   = 0;

  always #2.5 clk = ~clk;

  assign scl_in = !scl_drive_low && !stretch;

  scl_rate_gen u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable),
    .fast_mode(fast_mode), .divisor(divisor), .scl_in(scl_in),
    .scl_drive_low(scl_drive_low), .low_start(low_start),
    .high_start(high_start), .bad_setting(bad_setting)
  );

  always @(negedge clk) begin
    tcnt <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
    tick <= (tcnt == TDIV - 1);
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog expired: actual %0d cycles, expected under 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // {fast, divisor, low ticks, high ticks}
  localparam logic [19:0] VEC [8] = '{
    {1'b0, 5'd5,  7'd20,  7'd20},
    {1'b0, 5'd12, 7'd48,  7'd48},
    {1'b0, 5'd31, 7'd124, 7'd124},
    {1'b1, 5'd3,  7'd6,   7'd6},
    {1'b1, 5'd4,  7'd8,   7'd8},
    {1'b1, 5'd5,  7'd6,   7'd4},
    {1'b1, 5'd6,  7'd12,  7'd12},
    {1'b1, 5'd31, 7'd62,  7'd62}
  };

  task automatic wait_low_start(output int waited);
    waited = 0;
    while (!low_start && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
  endtask

  // Called at a negedge where low_start is 1.
  task automatic measure(input int stretch_cyc, output int lc, output int hc, output int hs);
    lc = 0;
    while (scl_drive_low && lc < 4000) begin
      lc++;
      @(negedge clk);
    end
    hc = 0;
    hs = 0;
    while (!low_start && hc < 4000) begin
      if (hc == 0 && stretch_cyc > 0) stretch = 1'b1;
      if (hc == stretch_cyc) stretch = 1'b0;
      if (high_start) hs++;
      hc++;
      @(negedge clk);
    end
    stretch = 1'b0;
  endtask

  task automatic start_cfg(input bit f, input int d, output int waited);
    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    fast_mode = f;
    divisor   = 5'(d);
    enable    = 1'b1;
    wait_low_start(waited);
  endtask

  initial begin
    int lc, hc, hs, w;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(!scl_drive_low && !low_start && !high_start, "R8 reset outputs", int'(scl_drive_low), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!scl_drive_low && !low_start && !high_start, "R8 after reset", int'(scl_drive_low), 0);

    foreach (VEC[i]) begin
      string req;
      req = !VEC[i][19] ? "R1" : (VEC[i][18:14] == 5'd5 ? "R3" : "R2");
      start_cfg(VEC[i][19], int'(VEC[i][18:14]), w);
      check(w >= 1 && w <= TDIV, "R9 first low on next tick", w, TDIV);
      check(bad_setting == 1'b0, {req, " legal flag"}, int'(bad_setting), 0);
      measure(0, lc, hc, hs);
      check(lc == TDIV * int'(VEC[i][13:7]), {req, " low length"}, lc, TDIV * int'(VEC[i][13:7]));
      check(hc == TDIV * int'(VEC[i][6:0]), {req, " high length"}, hc, TDIV * int'(VEC[i][6:0]));
      check(hs == 1, "R7 one high strobe per phase", hs, 1);
    end

    // R5: stretch by five ticks in fast mode, divisor 6
    start_cfg(1'b1, 6, w);
    measure(5 * TDIV, lc, hc, hs);
    check(hc == TDIV * (12 + 5), "R5 stretched high", hc, TDIV * 17);
    check(hs == 1, "R5 single high strobe under stretch", hs, 1);

    // R4: illegal settings
    for (int d = 0; d < 5; d++) begin
      for (int f = 0; f < 2; f++) begin
        if (f == 1 && d > 2) continue;
        @(negedge clk);
        fast_mode = f[0];
        divisor   = 5'(d);
        enable    = 1'b1;
        #1;
        check(bad_setting == 1'b1, "R4 illegal flag", int'(bad_setting), 1);
        for (int k = 0; k < 3 * TDIV; k++) begin
          @(negedge clk);
          check(!scl_drive_low && !low_start && !high_start, "R4 silent when illegal",
                int'(scl_drive_low) + int'(low_start) + int'(high_start), 0);
        end
      end
    end
    // R4: legal again starts a full low phase
    fast_mode = 1'b1;
    divisor   = 5'd8;
    wait_low_start(w);
    measure(0, lc, hc, hs);
    check(lc == TDIV * 16, "R4 recover full low", lc, TDIV * 16);

    // R6: drop enable mid low phase, then restart
    repeat (5) @(negedge clk);
    check(scl_drive_low == 1'b1, "R6 low phase running", int'(scl_drive_low), 1);
    enable = 1'b0;
    #1;
    check(scl_drive_low == 1'b0, "R6 immediate release", int'(scl_drive_low), 0);
    repeat (3) @(negedge clk);
    enable = 1'b1;
    wait_low_start(w);
    check(w >= 1 && w <= TDIV, "R9 restart on next tick", w, TDIV);
    measure(0, lc, hc, hs);
    check(lc == TDIV * 16, "R6 counters reset", lc, TDIV * 16);

    // R4: going illegal mid phase releases at once, then a fresh phase
    repeat (5) @(negedge clk);
    divisor = 5'd2;
    #1;
    check(scl_drive_low == 1'b0, "R4 illegal mid phase releases", int'(scl_drive_low), 0);
    @(negedge clk);
    divisor = 5'd8;
    wait_low_start(w);
    measure(0, lc, hc, hs);
    check(lc == TDIV * 16, "R4 fresh phase after illegal", lc, TDIV * 16);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule